// File: doc/BRIEF.md
# Low-Power Sleep Sequencer

This block sits beside a small 8-bit CPU core and decides when the core sleeps and when it wakes. When the core executes its sleep instruction, it raises a one-cycle strobe. If the sleep-enable bit is set at that moment and the mode select holds a legal code, the block stops the CPU clock. It also gates the peripheral clock domains to suit one of three sleep depths. The chosen depth is latched at entry, so later writes to the mode select do not change the sleep that is in progress.

Each depth accepts its own set of wake sources, all of them interrupt requests that have already been enabled upstream. An interrupt wake does not restart the CPU at once: the core stays halted for a fixed four-cycle window, and a resume pulse then tells it to service the interrupt and continue after the sleep instruction. For a pin-change wake out of the deepest mode, a flag-update pulse comes two cycles into that window. A reset request during sleep or during the hold window ends it at once and signals a restart from the reset vector. The block never clears retained processor state.

Top module: `sleep_manager`

## Requirements
- R1: A sleep strobe while running with sleepEn=0 is a no-op: cpuHalt stays 0.
- R2: modeSel=2'b11 (reserved) makes a sleep strobe a no-op even with sleepEn=1.
- R3: modeSel=2'b00 (idle) raises cpuHalt in the cycle after the strobe and keeps clkEnTimer, clkEnAdc and clkEnComp at 1. Any of extIrq, pinChg, timerIrq, adcIrq, compIrq or wdtIrq wakes the core.
- R4: adcStart pulses for one cycle, in the cycle after the strobe, only when idle is entered with adcEnabled=1. It never pulses for the other modes or with adcEnabled=0.
- R5: modeSel=2'b01 (ADC noise reduction) gives clkEnTimer=0, clkEnComp=0 and clkEnAdc=1. Wake comes from extIrq, pinChg, adcIrq or wdtIrq; timerIrq and compIrq are ignored.
- R6: modeSel=2'b10 (power-down) drives all three clock enables to 0. Wake comes from pinChg, wdtIrq, or extIrq while extIsLevel=1. timerIrq, adcIrq, and extIrq with extIsLevel=0 are ignored.
- R7: After an interrupt wake, cpuHalt stays 1 for exactly 4 further cycles with all clock enables at 1. cpuHalt then drops and resumeNext pulses in that first running cycle.
- R8: A pin-change wake from power-down pulses pinFlagSet in the third halted cycle after the wake, two cycles into the hold. Other wakes never pulse it.
- R9: rstReq during sleep or during the hold clears cpuHalt in the next cycle and pulses restartVec there. No resumeNext follows.
- R10: The sleep mode is captured at entry; a change of modeSel while asleep has no effect on the wake sources.
- R11: After reset, cpuHalt=0, all clock enables are 1 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| sleepEn | input | 1 | Sleep permission bit |
| modeSel | input | 2 | Sleep depth select: 00 idle, 01 ADC noise reduction, 10 power-down, 11 reserved |
| sleepStrobe | input | 1 | One-cycle pulse when the core executes a sleep instruction |
| rstReq | input | 1 | Synchronous chip reset request |
| adcEnabled | input | 1 | ADC is switched on |
| extIrq | input | 1 | Enabled external-pin interrupt request |
| extIsLevel | input | 1 | External interrupt uses level sensing |
| pinChg | input | 1 | Enabled pin-change event |
| timerIrq | input | 1 | Enabled timer interrupt request |
| adcIrq | input | 1 | Enabled conversion-complete interrupt request |
| compIrq | input | 1 | Enabled comparator interrupt request |
| wdtIrq | input | 1 | Watchdog wake request |
| cpuHalt | output | 1 | CPU clock gate: 1 stops the core |
| clkEnTimer | output | 1 | Timer domain clock enable |
| clkEnAdc | output | 1 | ADC domain clock enable |
| clkEnComp | output | 1 | Comparator domain clock enable |
| adcStart | output | 1 | One-cycle conversion start on entry to idle |
| resumeNext | output | 1 | One-cycle pulse: service interrupt, continue after sleep instruction |
| restartVec | output | 1 | One-cycle pulse: restart from the reset vector |
| pinFlagSet | output | 1 | One-cycle pulse: set the pin-change interrupt flag |

## Verification
The assertions assume that sleepStrobe comes only while the core runs, and that every wake source is synchronous to clk and already masked by its enable. They also assume that rstReq is a synchronous request, separate from the block reset. The stimulus raises each wake source for exactly one cycle, and only once the sleep state is established, never in the entry cycle. It applies rstReq only while the core is halted, and changes modeSel while asleep only to show that the latched depth wins.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_HOLD  = 2'd2
  } sleepState_e;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_ADCNR = 2'b01,
    MD_PDOWN = 2'b10,
    MD_RSVD  = 2'b11
  } sleepMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic enter;
    logic wake;
    logic finish;
    logic abort;
  } ctrlStrobe_t;

  // Wake source positions in the source vector
  localparam int SRC_W     = 6;
  localparam int SRC_EXT   = 0;
  localparam int SRC_PIN   = 1;
  localparam int SRC_TIMER = 2;
  localparam int SRC_ADC   = 3;
  localparam int SRC_COMP  = 4;
  localparam int SRC_WDT   = 5;

  function automatic logic [SRC_W-1:0] wakeMask(sleepMode_e md, logic extLevel);
    logic [SRC_W-1:0] m;
    m = '0;
    unique case (md)
      MD_IDLE: m = '1;
      MD_ADCNR: begin
        m[SRC_EXT] = 1'b1;
        m[SRC_PIN] = 1'b1;
        m[SRC_ADC] = 1'b1;
        m[SRC_WDT] = 1'b1;
      end
      MD_PDOWN: begin
        m[SRC_EXT] = extLevel;
        m[SRC_PIN] = 1'b1;
        m[SRC_WDT] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepStrobe,
  input  logic        sleepEn,
  input  logic [1:0]  modeSel,
  input  logic        rstReq,
  input  logic        wakeHit,
  input  logic        holdDone,
  output sleepState_e state,
  output ctrlStrobe_t strb
);

  sleepState_e nxtState;
  logic        entryOk;

  assign entryOk = sleepStrobe && sleepEn && (sleepMode_e'(modeSel) != MD_RSVD) && !rstReq;

  always_comb begin
    nxtState = state;
    strb     = '0;
    unique case (state)
      ST_RUN: begin
        if (entryOk) begin
          strb.enter = 1'b1;
          nxtState   = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (rstReq) begin
          strb.abort = 1'b1;
          nxtState   = ST_RUN;
        end else if (wakeHit) begin
          strb.wake = 1'b1;
          nxtState  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (rstReq) begin
          strb.abort = 1'b1;
          nxtState   = ST_RUN;
        end else if (holdDone) begin
          strb.finish = 1'b1;
          nxtState    = ST_RUN;
        end
      end
      default: nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nxtState;
  end

endmodule

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int PC_DELAY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  sleepState_e      state,
  input  logic [1:0]       modeSel,
  input  logic             adcEnabled,
  input  logic [SRC_W-1:0] srcVec,
  input  logic             extIsLevel,
  output logic             wakeHit,
  output logic             holdDone,
  output logic             clkEnTimer,
  output logic             clkEnAdc,
  output logic             clkEnComp,
  output logic             adcStart,
  output logic             resumeNext,
  output logic             restartVec,
  output logic             pinFlagSet
);

  localparam int CNT_W  = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam int PC_IDX = HOLD_CYC - 1 - PC_DELAY;

  sleepMode_e        curMode;
  logic [CNT_W-1:0]  holdCnt;
  logic              pcWake;

  // Latched depth and hold window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MD_IDLE;
      holdCnt <= '0;
      pcWake  <= 1'b0;
    end else begin
      if (strb.enter) curMode <= sleepMode_e'(modeSel);
      if (strb.wake) begin
        holdCnt <= CNT_W'(HOLD_CYC - 1);
        pcWake  <= (curMode == MD_PDOWN) && srcVec[SRC_PIN];
      end else if (state == ST_HOLD && holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
      if (strb.finish || strb.abort) pcWake <= 1'b0;
    end
  end

  // Registered single-cycle indications
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcStart   <= 1'b0;
      resumeNext <= 1'b0;
      restartVec <= 1'b0;
    end else begin
      adcStart   <= strb.enter && (sleepMode_e'(modeSel) == MD_IDLE) && adcEnabled;
      resumeNext <= strb.finish;
      restartVec <= strb.abort;
    end
  end

  assign wakeHit    = |(srcVec & wakeMask(curMode, extIsLevel));
  assign holdDone   = (holdCnt == '0);
  assign pinFlagSet = (state == ST_HOLD) && pcWake && (holdCnt == CNT_W'(PC_IDX));

  // Domain clock enables
  always_comb begin
    clkEnTimer = 1'b1;
    clkEnAdc   = 1'b1;
    clkEnComp  = 1'b1;
    if (state == ST_SLEEP) begin
      unique case (curMode)
        MD_ADCNR: begin
          clkEnTimer = 1'b0;
          clkEnComp  = 1'b0;
        end
        MD_PDOWN: begin
          clkEnTimer = 1'b0;
          clkEnAdc   = 1'b0;
          clkEnComp  = 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sleep_manager.sv
module sleep_manager
  import sleep_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int PC_DELAY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepEn,
  input  logic [1:0] modeSel,
  input  logic       sleepStrobe,
  input  logic       rstReq,
  input  logic       adcEnabled,
  input  logic       extIrq,
  input  logic       extIsLevel,
  input  logic       pinChg,
  input  logic       timerIrq,
  input  logic       adcIrq,
  input  logic       compIrq,
  input  logic       wdtIrq,
  output logic       cpuHalt,
  output logic       clkEnTimer,
  output logic       clkEnAdc,
  output logic       clkEnComp,
  output logic       adcStart,
  output logic       resumeNext,
  output logic       restartVec,
  output logic       pinFlagSet
);

  sleepState_e      fsmState;
  ctrlStrobe_t      strb;
  logic             wakeHit;
  logic             holdDone;
  logic [SRC_W-1:0] srcVec;

  always_comb begin
    srcVec            = '0;
    srcVec[SRC_EXT]   = extIrq;
    srcVec[SRC_PIN]   = pinChg;
    srcVec[SRC_TIMER] = timerIrq;
    srcVec[SRC_ADC]   = adcIrq;
    srcVec[SRC_COMP]  = compIrq;
    srcVec[SRC_WDT]   = wdtIrq;
  end

  sleep_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .sleepStrobe (sleepStrobe),
    .sleepEn     (sleepEn),
    .modeSel     (modeSel),
    .rstReq      (rstReq),
    .wakeHit     (wakeHit),
    .holdDone    (holdDone),
    .state       (fsmState),
    .strb        (strb)
  );

  sleep_dp #(
    .HOLD_CYC (HOLD_CYC),
    .PC_DELAY (PC_DELAY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .state      (fsmState),
    .modeSel    (modeSel),
    .adcEnabled (adcEnabled),
    .srcVec     (srcVec),
    .extIsLevel (extIsLevel),
    .wakeHit    (wakeHit),
    .holdDone   (holdDone),
    .clkEnTimer (clkEnTimer),
    .clkEnAdc   (clkEnAdc),
    .clkEnComp  (clkEnComp),
    .adcStart   (adcStart),
    .resumeNext (resumeNext),
    .restartVec (restartVec),
    .pinFlagSet (pinFlagSet)
  );

  assign cpuHalt = (fsmState != ST_RUN);

endmodule

// File: rtl/sleep_manager_chk.sv
module sleep_manager_chk
  import sleep_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        sleepEn,
  input logic [1:0]  modeSel,
  input logic        sleepStrobe,
  input logic        rstReq,
  input logic        adcEnabled,
  input logic        cpuHalt,
  input logic        clkEnTimer,
  input logic        clkEnAdc,
  input logic        clkEnComp,
  input logic        adcStart,
  input logic        resumeNext,
  input logic        restartVec,
  input logic        pinFlagSet,
  input sleepState_e fsmState
);

  int unsigned holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   holdRun <= 0;
    else if (fsmState == ST_HOLD) holdRun <= holdRun + 1;
    else                         holdRun <= 0;
  end

  a_r1_no_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHalt && sleepStrobe && !sleepEn) |=> !cpuHalt);

  a_r2_reserved_noop: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHalt && sleepStrobe && modeSel == 2'b11) |=> !cpuHalt);

  a_r4_adc_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(!cpuHalt && sleepStrobe && sleepEn && modeSel == 2'b00 && adcEnabled && !rstReq));

  a_r5_timer_gated_only_asleep: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnTimer |-> cpuHalt);

  a_r6_adc_off_all_off: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnAdc |-> (!clkEnTimer && !clkEnComp));

  a_r7_hold_length: assert property (@(posedge clk) disable iff (!rstN)
    resumeNext |-> (holdRun == HOLD_CYC && !cpuHalt));

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adcStart, resumeNext, restartVec}));

  a_r8_pin_flag_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    pinFlagSet |-> (fsmState == ST_HOLD));

  a_r9_restart_cause: assert property (@(posedge clk) disable iff (!rstN)
    restartVec |-> ($past(rstReq && cpuHalt) && !cpuHalt));

endmodule

bind sleep_manager sleep_manager_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepEn     (sleepEn),
  .modeSel     (modeSel),
  .sleepStrobe (sleepStrobe),
  .rstReq      (rstReq),
  .adcEnabled  (adcEnabled),
  .cpuHalt     (cpuHalt),
  .clkEnTimer  (clkEnTimer),
  .clkEnAdc    (clkEnAdc),
  .clkEnComp   (clkEnComp),
  .adcStart    (adcStart),
  .resumeNext  (resumeNext),
  .restartVec  (restartVec),
  .pinFlagSet  (pinFlagSet),
  .fsmState    (fsmState)
);

// File: tb/tb_sleep_manager.sv
`timescale 1ns/1ps
module tb_sleep_manager;

  localparam int S_EXT = 0, S_PIN = 1, S_TIMER = 2, S_ADC = 3, S_COMP = 4, S_WDT = 5;
  localparam int E_ADC = 0, E_RESUME = 1, E_RESTART = 2, E_PIN = 3;

  logic clk = 1'b0;
  logic rstN;
  logic sleepEn, sleepStrobe, rstReq, adcEnabled;
  logic [1:0] modeSel;
  logic extIrq, extIsLevel, pinChg, timerIrq, adcIrq, compIrq, wdtIrq;
  logic cpuHalt, clkEnTimer, clkEnAdc, clkEnComp;
  logic adcStart, resumeNext, restartVec, pinFlagSet;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } evt_t;
  evt_t expQ[$];

  always #4 clk = ~clk;

  sleep_manager dut (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel),
    .sleepStrobe(sleepStrobe), .rstReq(rstReq), .adcEnabled(adcEnabled),
    .extIrq(extIrq), .extIsLevel(extIsLevel), .pinChg(pinChg),
    .timerIrq(timerIrq), .adcIrq(adcIrq), .compIrq(compIrq), .wdtIrq(wdtIrq),
    .cpuHalt(cpuHalt), .clkEnTimer(clkEnTimer), .clkEnAdc(clkEnAdc),
    .clkEnComp(clkEnComp), .adcStart(adcStart), .resumeNext(resumeNext),
    .restartVec(restartVec), .pinFlagSet(pinFlagSet)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void push(int kind, int at, string req);
    evt_t e;
    e.kind = kind;
    e.at   = at;
    e.req  = req;
    expQ.push_back(e);
  endfunction

  // Scoreboard monitor: samples away from the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      if (rstN) begin
        logic [3:0] seen;
        seen = {pinFlagSet, restartVec, resumeNext, adcStart};
        for (int k = 0; k < 4; k++) begin
          if (seen[k]) begin
            checks++;
            if (expQ.size() == 0) begin
              failures++;
              $display("FAIL unexpected event actual=kind%0d@%0d expected=none", k, cyc);
            end else begin
              evt_t e;
              e = expQ.pop_front();
              if (e.kind != k || e.at != cyc) begin
                failures++;
                $display("FAIL %s event actual=kind%0d@%0d expected=kind%0d@%0d",
                         e.req, k, cyc, e.kind, e.at);
              end
            end
          end
        end
        while (expQ.size() > 0 && expQ[0].at < cyc) begin
          evt_t e;
          e = expQ.pop_front();
          checks++;
          failures++;
          $display("FAIL %s missing event actual=none expected=kind%0d@%0d", e.req, e.kind, e.at);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enterSleep(logic [1:0] md, logic adcOn, string req);
    tick();
    sleepEn     = 1'b1;
    modeSel     = md;
    adcEnabled  = adcOn;
    sleepStrobe = 1'b1;
    if (md == 2'b00 && adcOn) push(E_ADC, cyc + 1, req);
    tick();
    sleepStrobe = 1'b0;
    chk(req, "cpuHalt after entry", int'(cpuHalt), 1);
  endtask

  // Raise one source for one cycle; ends at the following negedge
  task automatic pulseSrc(int idx, bit expWake, bit expPin, string req);
    tick();
    case (idx)
      S_EXT:   extIrq   = 1'b1;
      S_PIN:   pinChg   = 1'b1;
      S_TIMER: timerIrq = 1'b1;
      S_ADC:   adcIrq   = 1'b1;
      S_COMP:  compIrq  = 1'b1;
      default: wdtIrq   = 1'b1;
    endcase
    if (expWake) begin
      if (expPin) push(E_PIN, cyc + 3, req);
      push(E_RESUME, cyc + 5, req);
    end
    tick();
    {extIrq, pinChg, timerIrq, adcIrq, compIrq, wdtIrq} = '0;
    chk(req, "cpuHalt after source pulse", int'(cpuHalt), 1);
  endtask

  // Called one cycle after a waking pulse: three more halted cycles, then run
  task automatic waitResume(string req);
    chk("R7", "clkEnTimer in hold", int'(clkEnTimer), 1);
    chk("R7", "clkEnAdc in hold", int'(clkEnAdc), 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7", "cpuHalt in hold", int'(cpuHalt), 1);
    end
    tick();
    chk(req, "cpuHalt after hold", int'(cpuHalt), 0);
  endtask

  task automatic chkEn(string req, int t, int a, int c);
    chk(req, "clkEnTimer", int'(clkEnTimer), t);
    chk(req, "clkEnAdc", int'(clkEnAdc), a);
    chk(req, "clkEnComp", int'(clkEnComp), c);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    sleepEn = 0; sleepStrobe = 0; rstReq = 0; adcEnabled = 0; modeSel = 2'b00;
    {extIrq, extIsLevel, pinChg, timerIrq, adcIrq, compIrq, wdtIrq} = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R11 reset state
    chk("R11", "cpuHalt", int'(cpuHalt), 0);
    chkEn("R11", 1, 1, 1);
    chk("R11", "pulses", int'({adcStart, resumeNext, restartVec, pinFlagSet}), 0);

    // R1 strobe without enable
    tick();
    sleepEn = 0; modeSel = 2'b00; adcEnabled = 1; sleepStrobe = 1;
    tick();
    sleepStrobe = 0;
    chk("R1", "cpuHalt", int'(cpuHalt), 0);

    // R2 reserved mode
    tick();
    sleepEn = 1; modeSel = 2'b11; sleepStrobe = 1;
    tick();
    sleepStrobe = 0;
    chk("R2", "cpuHalt", int'(cpuHalt), 0);

    // R3/R4/R7 idle with ADC, wake by timer
    enterSleep(2'b00, 1'b1, "R4");
    chkEn("R3", 1, 1, 1);
    repeat (2) tick();
    pulseSrc(S_TIMER, 1, 0, "R7");
    waitResume("R7");

    // R4 idle without ADC start; wake by comparator
    enterSleep(2'b00, 1'b0, "R4");
    pulseSrc(S_COMP, 1, 0, "R3");
    waitResume("R3");

    // R3 idle wake by external and watchdog
    enterSleep(2'b00, 1'b0, "R3");
    pulseSrc(S_EXT, 1, 0, "R3");
    waitResume("R3");
    enterSleep(2'b00, 1'b0, "R3");
    pulseSrc(S_WDT, 1, 0, "R3");
    waitResume("R3");

    // R5 noise reduction, ADC on but no start pulse (R4)
    enterSleep(2'b01, 1'b1, "R5");
    chkEn("R5", 0, 1, 0);
    pulseSrc(S_TIMER, 0, 0, "R5");
    pulseSrc(S_COMP, 0, 0, "R5");
    modeSel = 2'b00;                    // R10: latched depth stays
    pulseSrc(S_TIMER, 0, 0, "R10");
    chkEn("R10", 0, 1, 0);
    pulseSrc(S_ADC, 1, 0, "R5");
    waitResume("R5");

    // R6 power-down
    extIsLevel = 1'b0;
    enterSleep(2'b10, 1'b1, "R6");
    chkEn("R6", 0, 0, 0);
    pulseSrc(S_TIMER, 0, 0, "R6");
    pulseSrc(S_ADC, 0, 0, "R6");
    pulseSrc(S_COMP, 0, 0, "R6");
    pulseSrc(S_EXT, 0, 0, "R6");
    pulseSrc(S_PIN, 1, 1, "R8");
    waitResume("R8");

    // R8 watchdog wake from power-down: no flag pulse
    enterSleep(2'b10, 1'b0, "R8");
    pulseSrc(S_WDT, 1, 0, "R8");
    waitResume("R8");

    // R8 pin change from idle: no flag pulse
    enterSleep(2'b00, 1'b0, "R8");
    pulseSrc(S_PIN, 1, 0, "R8");
    waitResume("R8");

    // R6 level external wake
    extIsLevel = 1'b1;
    enterSleep(2'b10, 1'b0, "R6");
    pulseSrc(S_EXT, 1, 0, "R6");
    waitResume("R6");
    extIsLevel = 1'b0;

    // R9 reset request during sleep
    enterSleep(2'b01, 1'b0, "R9");
    tick();
    rstReq = 1'b1;
    push(E_RESTART, cyc + 1, "R9");
    tick();
    rstReq = 1'b0;
    chk("R9", "cpuHalt after reset in sleep", int'(cpuHalt), 0);

    // R9 reset request during hold
    enterSleep(2'b00, 1'b0, "R9");
    pulseSrc(S_EXT, 0, 0, "R9");
    tick();
    rstReq = 1'b1;
    push(E_RESTART, cyc + 1, "R9");
    tick();
    rstReq = 1'b0;
    chk("R9", "cpuHalt after reset in hold", int'(cpuHalt), 0);

    repeat (8) tick();
    chk("R9", "outstanding events", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule